// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block is a synthesizable cycle model of the digital readout logic of a linear contact image sensor with four selectable resolutions. It serves as a stand-in for the sensor in a test environment or as an emulator. Every falling edge of the sensor clock samples three inputs: a global start, a chip select and a resolution-select pin. A start accepted on one edge opens a scan. The first 100 clocks of the scan are a silent preamble. After the preamble, one pixel index is presented per clock until the last pixel of the chosen resolution. The sequencer also raises an amplifier-enable flag for the length of the scan and emits a one-clock end-of-scan pulse. That pulse feeds the start of the next chip in a chain and arrives 24 pixels before the last pixel.

The resolution is not set by a static pin level. The select pin is sampled in two three-clock windows inside the preamble, and the combination of the two windows picks one of four modes. The mode stays frozen from the close of the second window to the end of the scan. Protocol misuse raises sticky error flags: a window that does not hold a uniform level, or a start held over two consecutive samples. Both flags clear on the next fresh start.

Top module: `lsr_readout`

## Requirements
- R1: While reset is asserted, the block shows no scan activity. Pixel-valid, end-of-scan, amplifier enable and both error flags are low, and the mode output reads 0.
- R2: A start is accepted on the falling edge where the global start and chip select are both sampled high and were not both high on the previous edge. The clock that follows is scan clock 1, and amplifier enable is high from that clock on. A global start sampled while chip select is low has no effect.
- R3: During scan clocks 1 to 100, pixel-valid stays low.
- R4: Scan clock 100+n presents pixel index n with pixel-valid high, one new index per clock. After the last pixel, the next clock drops pixel-valid and amplifier enable and the block returns to idle.
- R5: The select-pin samples taken at the edges that close scan clocks 20–22 (window A) and 44–46 (window B) set the mode output. A and B both high gives 0 (full resolution). Both low gives 1 (three-quarter). A low with B high gives 2 (half). A high with B low gives 3 (quarter). The new mode is visible from scan clock 47.
- R6: The last pixel index is 232, 174, 116 or 58 for modes 0, 1, 2 and 3.
- R7: End-of-scan is a single-clock pulse that coincides with pixel 208, 150, 92 or 34 for modes 0, 1, 2 and 3.
- R8: A window holding mixed samples selects mode 0 and sets the mode-error flag. Select-pin values outside the two windows have no effect on the mode or the scan.
- R9: A start sampled on two consecutive edges counts as one start. The scan is not restarted, and the duplicate-start flag is set from the next clock.
- R10: A fresh start during a running scan restarts it at scan clock 1, and each fresh start clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sensor clock; all state changes on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gbst_i | input | 1 | Global start request |
| sel_i | input | 1 | Chip select; tie high for a single chip |
| res_i | input | 1 | Resolution-select pin, sampled in the two windows |
| pix_valid_o | output | 1 | Active pixel is presented this clock |
| pix_idx_o | output | 8 | Index of the active pixel, 1-based; 0 when not valid |
| eos_o | output | 1 | End-of-scan pulse for chaining to the next chip |
| amp_en_o | output | 1 | Output amplifier powered |
| res_mode_o | output | 2 | Decoded resolution mode (0 full, 1 three-quarter, 2 half, 3 quarter) |
| mode_err_o | output | 1 | A resolution window held mixed samples |
| dup_err_o | output | 1 | Start was sampled on two consecutive edges |

## Verification
All outputs are registered on the falling edge, so a falling-edge sample settles a result one clock later. If a start is driven before falling edge 0, the outputs for scan clock k can be read at the k-th rising edge after it. The bench drives inputs and reads outputs only on rising edges, half a period away from the sampling edge. It keeps a scan clock number of its own, so every check compares the outputs against the expected values for that clock number. The duplicate-start flag and the mode are due one clock after the edge that produced them: clock 2 and clock 47 respectively. The bench reads them at or after those clocks.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  typedef enum logic [1:0] {
    RES_FULL = 2'd0,
    RES_3Q   = 2'd1,
    RES_HALF = 2'd2,
    RES_QTR  = 2'd3
  } res_e;

  // Active pixels in a mode, as quarters of the full line.
  function automatic int unsigned last_pixel(res_e m, int unsigned full);
    int unsigned quarters;
    unique case (m)
      RES_FULL: quarters = 4;
      RES_3Q:   quarters = 3;
      RES_HALF: quarters = 2;
      default:  quarters = 1;
    endcase
    return (full * quarters) / 4;
  endfunction

  // End-of-scan pixel sits a fixed lead before the last pixel.
  function automatic int unsigned eos_pixel(res_e m, int unsigned full, int unsigned lead);
    return last_pixel(m, full) - lead;
  endfunction

  // Window flags: *_hi = every sample high, *_lo = every sample low.
  function automatic logic windows_uniform(logic a_hi, logic a_lo, logic b_hi, logic b_lo);
    return (a_hi | a_lo) & (b_hi | b_lo);
  endfunction

  function automatic res_e decode_windows(logic a_hi, logic a_lo, logic b_hi, logic b_lo);
    if (a_hi && b_hi)      return RES_FULL;
    else if (a_lo && b_lo) return RES_3Q;
    else if (a_lo && b_hi) return RES_HALF;
    else if (a_hi && b_lo) return RES_QTR;
    return RES_FULL;
  endfunction

endpackage

// File: rtl/lsr_start_sync.sv
module lsr_start_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gbst_i,
  input  logic sel_i,
  output logic fresh_o,
  output logic dup_o,
  output logic dup_err_o
);
  logic req;
  logic req_q;

  assign req     = gbst_i & sel_i;
  assign fresh_o = req & ~req_q;
  assign dup_o   = req & req_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      dup_err_o <= 1'b0;
    end else begin
      req_q <= req;
      if (fresh_o)    dup_err_o <= 1'b0;
      else if (dup_o) dup_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lsr_scan_counter.sv
module lsr_scan_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fresh_i,
  input  logic [CNT_W-1:0] end_clk_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  assign done_o = (cnt_o == end_clk_i) && !fresh_i;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (fresh_i)         cnt_o <= CNT_W'(1);
    else if (done_o)          cnt_o <= '0;
    else if (cnt_o != '0)     cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/lsr_mode_decode.sv
module lsr_mode_decode
  import lsr_pkg::*;
#(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned WIN_A   = 20,
  parameter int unsigned WIN_B   = 44,
  parameter int unsigned WIN_LEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fresh_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             res_i,
  output res_e             mode_o,
  output logic             mode_err_o
);
  localparam logic [CNT_W-1:0] A_LO = CNT_W'(WIN_A);
  localparam logic [CNT_W-1:0] A_HI = CNT_W'(WIN_A + WIN_LEN - 1);
  localparam logic [CNT_W-1:0] B_LO = CNT_W'(WIN_B);
  localparam logic [CNT_W-1:0] B_HI = CNT_W'(WIN_B + WIN_LEN - 1);

  logic in_a, in_b, close_b;
  logic a_hi, a_lo, b_hi, b_lo;
  logic b_hi_n, b_lo_n;

  assign in_a    = (cnt_i >= A_LO) && (cnt_i <= A_HI);
  assign in_b    = (cnt_i >= B_LO) && (cnt_i <= B_HI);
  assign close_b = (cnt_i == B_HI);
  assign b_hi_n  = b_hi & (~in_b | res_i);
  assign b_lo_n  = b_lo & (~in_b | ~res_i);

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_hi <= 1'b1; a_lo <= 1'b1; b_hi <= 1'b1; b_lo <= 1'b1;
      mode_o     <= RES_FULL;
      mode_err_o <= 1'b0;
    end else if (fresh_i) begin
      a_hi <= 1'b1; a_lo <= 1'b1; b_hi <= 1'b1; b_lo <= 1'b1;
      mode_err_o <= 1'b0;
    end else begin
      if (in_a) begin
        a_hi <= a_hi & res_i;
        a_lo <= a_lo & ~res_i;
      end
      b_hi <= b_hi_n;
      b_lo <= b_lo_n;
      if (close_b) begin
        mode_o     <= decode_windows(a_hi, a_lo, b_hi_n, b_lo_n);
        mode_err_o <= ~windows_uniform(a_hi, a_lo, b_hi_n, b_lo_n);
      end
    end
  end
endmodule

// File: rtl/lsr_readout.sv
module lsr_readout
  import lsr_pkg::*;
#(
  parameter int unsigned PRE_CLKS = 100,
  parameter int unsigned FULL_PIX = 232,
  parameter int unsigned EOS_LEAD = 24,
  parameter int unsigned WIN_A    = 20,
  parameter int unsigned WIN_B    = 44,
  parameter int unsigned WIN_LEN  = 3,
  parameter int unsigned IDX_W    = $clog2(FULL_PIX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gbst_i,
  input  logic             sel_i,
  input  logic             res_i,
  output logic             pix_valid_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             eos_o,
  output logic             amp_en_o,
  output logic [1:0]       res_mode_o,
  output logic             mode_err_o,
  output logic             dup_err_o
);
  localparam int unsigned CNT_W = $clog2(PRE_CLKS + FULL_PIX + 1);
  localparam logic [CNT_W-1:0] PRE_C = CNT_W'(PRE_CLKS);

  // Named internal events, visible to the bound checker.
  logic             scan_start;
  logic             start_dup;
  logic             scan_done;
  logic [CNT_W-1:0] clk_num;
  logic [CNT_W-1:0] end_clk;
  res_e             mode;

  lsr_start_sync u_start (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gbst_i   (gbst_i),
    .sel_i    (sel_i),
    .fresh_o  (scan_start),
    .dup_o    (start_dup),
    .dup_err_o(dup_err_o)
  );

  lsr_scan_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fresh_i  (scan_start),
    .end_clk_i(end_clk),
    .cnt_o    (clk_num),
    .done_o   (scan_done)
  );

  lsr_mode_decode #(
    .CNT_W  (CNT_W),
    .WIN_A  (WIN_A),
    .WIN_B  (WIN_B),
    .WIN_LEN(WIN_LEN)
  ) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fresh_i   (scan_start),
    .cnt_i     (clk_num),
    .res_i     (res_i),
    .mode_o    (mode),
    .mode_err_o(mode_err_o)
  );

  assign end_clk     = CNT_W'(PRE_CLKS + last_pixel(mode, FULL_PIX));
  assign pix_valid_o = (clk_num > PRE_C) && (clk_num <= end_clk);
  assign pix_idx_o   = pix_valid_o ? IDX_W'(clk_num - PRE_C) : '0;
  assign eos_o       = pix_valid_o &&
                       (pix_idx_o == IDX_W'(eos_pixel(mode, FULL_PIX, EOS_LEAD)));
  assign amp_en_o    = (clk_num != '0);
  assign res_mode_o  = mode;
endmodule

// File: rtl/lsr_readout_chk.sv
module lsr_readout_chk #(
  parameter int unsigned PRE_CLKS = 100,
  parameter int unsigned WIN_B    = 44,
  parameter int unsigned WIN_LEN  = 3,
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned IDX_W    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scan_start,
  input logic             start_dup,
  input logic [CNT_W-1:0] clk_num,
  input logic             pix_valid_o,
  input logic [IDX_W-1:0] pix_idx_o,
  input logic             eos_o,
  input logic             amp_en_o,
  input logic [1:0]       res_mode_o,
  input logic             mode_err_o,
  input logic             dup_err_o
);
  localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(PRE_CLKS);
  localparam logic [CNT_W-1:0] FROZEN = CNT_W'(WIN_B + WIN_LEN - 1);

  AST_START_CLK1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    scan_start |=> (clk_num == CNT_W'(1)) && amp_en_o); // R2

  AST_PRESCAN_QUIET: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (clk_num != '0 && clk_num <= PRE_C) |-> !pix_valid_o); // R3

  AST_IDX_STEP: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !scan_start) |=>
      (!pix_valid_o || pix_idx_o == $past(pix_idx_o) + IDX_W'(1))); // R4

  AST_AMP_DROP: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(amp_en_o) |-> $past(pix_valid_o)); // R4

  AST_EOS_IN_SCAN: assert property (@(negedge clk_i) disable iff (!rst_ni)
    eos_o |-> pix_valid_o && amp_en_o); // R7

  AST_EOS_SINGLE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    eos_o |=> !eos_o); // R7

  AST_MODE_FROZEN: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (clk_num > FROZEN && !scan_start) |=> $stable(res_mode_o)); // R8

  AST_ERR_FALLBACK: assert property (@(negedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> (res_mode_o == 2'd0)); // R8

  AST_DUP_FLAG: assert property (@(negedge clk_i) disable iff (!rst_ni)
    start_dup |=> dup_err_o && (clk_num != CNT_W'(1))); // R9

  AST_RESTART_CLEAR: assert property (@(negedge clk_i) disable iff (!rst_ni)
    scan_start |=> !mode_err_o && !dup_err_o); // R10
endmodule

bind lsr_readout lsr_readout_chk #(
  .PRE_CLKS(PRE_CLKS),
  .WIN_B   (WIN_B),
  .WIN_LEN (WIN_LEN),
  .CNT_W   (CNT_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scan_start (scan_start),
  .start_dup  (start_dup),
  .clk_num    (clk_num),
  .pix_valid_o(pix_valid_o),
  .pix_idx_o  (pix_idx_o),
  .eos_o      (eos_o),
  .amp_en_o   (amp_en_o),
  .res_mode_o (res_mode_o),
  .mode_err_o (mode_err_o),
  .dup_err_o  (dup_err_o)
);

// File: tb/lsr_readout_tb.sv
module lsr_readout_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gbst = 1'b0;
  logic       sel = 1'b0;
  logic       res = 1'b0;
  logic       pix_valid;
  logic [7:0] pix_idx;
  logic       eos;
  logic       amp_en;
  logic [1:0] res_mode;
  logic       mode_err;
  logic       dup_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lsr_readout u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .gbst_i     (gbst),
    .sel_i      (sel),
    .res_i      (res),
    .pix_valid_o(pix_valid),
    .pix_idx_o  (pix_idx),
    .eos_o      (eos),
    .amp_en_o   (amp_en),
    .res_mode_o (res_mode),
    .mode_err_o (mode_err),
    .dup_err_o  (dup_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lines_of(input int m);
    return (232 * (4 - m)) / 4;
  endfunction

  // Select-pin level for scan clock c; outside both windows it toggles.
  function automatic logic pin_level(input int ptype, input int c);
    bit in_a = (c >= 20 && c <= 22);
    bit in_b = (c >= 44 && c <= 46);
    if (!in_a && !in_b) return c[0];
    case (ptype)
      0: return 1'b1;
      1: return 1'b0;
      2: return in_b;
      3: return in_a;
      default: return (c == 21) ? 1'b0 : 1'b1;
    endcase
  endfunction

  task automatic run_scan(input int ptype, input int exp_mode, input bit exp_merr,
                          input bit dup, input int restart_at);
    int  last = lines_of(exp_mode);
    int  c = 0;
    bit  restarted = 1'b0;
    bit  ev;
    @(posedge clk);
    gbst <= 1'b1;
    sel  <= 1'b1;
    res  <= pin_level(ptype, 0);
    while (1) begin
      @(posedge clk);
      c++;
      ev = (c > 100) && (c <= 100 + last);
      chk(pix_valid == ev, (c <= 100) ? "R3" : "R4", pix_valid, ev);
      if (ev) chk(pix_idx == 8'(c - 100), "R4", pix_idx, c - 100);
      chk(eos == (ev && (c - 100 == last - 24)), "R7", eos, ev && (c - 100 == last - 24));
      chk(amp_en == (c <= 100 + last), (c <= 100 + last) ? "R2" : "R4", amp_en, c <= 100 + last);
      if (c == 1) begin
        chk(mode_err == 1'b0, "R10", mode_err, 0);
        chk(dup_err == 1'b0, "R10", dup_err, 0);
        if (restarted) chk(amp_en && !pix_valid, "R10", pix_valid, 0);
      end
      if (c == 2 && dup) chk(dup_err == 1'b1, "R9", dup_err, 1);
      if (c == 47 || c == 100 + last) begin
        chk(res_mode == 2'(exp_mode), "R5", res_mode, exp_mode);
        chk(mode_err == exp_merr, "R8", mode_err, exp_merr);
      end
      if (c == 100 + last) chk(pix_idx == 8'(last), "R6", pix_idx, last);
      if (c == 101 + last) begin
        chk(!pix_valid, "R6", pix_valid, 0);
        if (dup) chk(dup_err == 1'b1, "R9", dup_err, 1);
        break;
      end
      gbst <= (dup && c == 1 && !restarted) || (c == restart_at && !restarted);
      res  <= pin_level(ptype, c);
      if (c == restart_at && !restarted) begin
        restarted = 1'b1;
        c = 0;
      end
    end
    gbst <= 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    chk(!pix_valid && !eos && !amp_en, "R1", {pix_valid, eos, amp_en}, 0);
    chk(res_mode == 2'd0 && !mode_err && !dup_err, "R1", {res_mode, mode_err, dup_err}, 0);
    rst_n <= 1'b1;
    @(posedge clk);

    // Global start with chip select low must be ignored.
    gbst <= 1'b1;
    sel  <= 1'b0;
    @(posedge clk);
    gbst <= 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      chk(!amp_en && !pix_valid, "R2", amp_en, 0);
    end

    run_scan(0, 0, 1'b0, 1'b0, -1); // full
    run_scan(1, 1, 1'b0, 1'b0, -1); // three-quarter
    run_scan(2, 2, 1'b0, 1'b0, -1); // half
    run_scan(3, 3, 1'b0, 1'b0, -1); // quarter
    run_scan(4, 0, 1'b1, 1'b0, -1); // mixed window -> fallback
    run_scan(3, 3, 1'b0, 1'b1, -1); // duplicate start, flags cleared first
    run_scan(2, 2, 1'b0, 1'b0, 150); // restart during active pixels

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule